// File: doc/BRIEF.md
# Four-Channel PWM Timer with Reload Interrupts

This block holds four edge-aligned PWM channels behind a simple register-write bus. Each channel counts up from zero to its period value and drives its output high while the count is below its width value. Period and width are written into holding copies; a channel copies them into its working registers only when a new cycle begins. The same event raises that channel's request flag, which tells software that fresh values may be written.

The four request flags and the four run bits share the first control word. A second control word carries per-channel interrupt enables, per-channel single-shot bits and a burst bit. Software can write that second word whole, or change single bits through a set alias and a clear alias. A single interrupt output is the OR of every request flag whose enable is set. In burst mode, output 0 carries the AND of channels 0 and 1. A single-shot channel runs exactly one cycle and then stops by itself.

Top module: `pwm4_irq`

## Requirements
- R1: After reset both control words, all period and width values, all outputs and the interrupt read or drive 0.
- R2: Address map: 0 = control A (run bits 3:0, request flags 11:8), 1 = control B direct, 2 = set alias, 3 = clear alias, 8+2c = period of channel c, 9+2c = width of channel c. A channel counts 0..period and repeats, so a cycle lasts period+1 clocks. Its output is high while count < width. Period and width writes take effect only at the next cycle start.
- R3: A width of 0 holds the output low. A width above the period holds it high.
- R4: Setting a run bit starts the channel with count 0 on the next clock. Each cycle start, whether the first one or a wrap, loads the held period and width and sets that channel's request flag.
- R5: The interrupt output is high exactly when some request flag is 1 and its enable in control B bits 3:0 is 1.
- R6: Writing control A with a 0 in a flag bit clears that flag, and a 1 leaves it as it is. If a cycle start falls on the same clock as the clearing write, the flag stays set.
- R7: Writing the set alias sets each control B bit that has a 1 in the data. Zero bits have no effect.
- R8: Writing the clear alias clears each control B bit that has a 1 in the data. Zero bits have no effect.
- R9: Only control B bits 15, 14, 12 and 7:0 exist. The other bits ignore writes and read 0. The set and clear aliases read 0.
- R10: While control B bit 12 (burst) is 1, output 0 equals channel 0 AND channel 1. Output 1 always shows channel 1 alone.
- R11: While control B bit 4+c is 1, channel c stops at the end of its current cycle. Its run bit is cleared, its output goes low, and no reload or flag follows.
- R12: Clearing a run bit stops the channel on the next clock and holds its output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| pwm_out | output | 4 | Channel outputs, burst-gated on bit 0 |
| irq | output | 1 | Module interrupt |

## Verification
Two events can land on the same clock edge: a software write that clears a request flag, and the hardware reload that sets that flag. The bench runs a channel with a known period and times a clearing write so that it is captured on the wrap edge. The flag must then read 1. A second write, captured in the middle of the cycle, must read 0. A similar collision is checked for a width write captured on the reload edge: the old held value must be loaded, and the new one must appear only one cycle later.

// File: rtl/pwm4_irq.sv
module pwm4_irq #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic [3:0]  pwm_out,
  output logic        irq
);
  localparam int NCH = 4;
  localparam logic [15:0] B_MASK = 16'hD0FF;

  logic [NCH-1:0] run, flag, active, reload, fin, raw;
  logic [15:0]    ctrlb;
  logic [CW-1:0]  per_h [NCH];
  logic [CW-1:0]  wid_h [NCH];
  logic [CW-1:0]  per_a [NCH];
  logic [CW-1:0]  wid_a [NCH];
  logic [CW-1:0]  cnt   [NCH];

  wire [NCH-1:0] ien   = ctrlb[3:0];
  wire [NCH-1:0] ss    = ctrlb[7:4];
  wire           burst = ctrlb[12];
  wire [15:0]    wmask = wr_data & B_MASK;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      fin[c]    = active[c] && cnt[c] == per_a[c] && ss[c];
      reload[c] = run[c] && (!active[c] || (cnt[c] == per_a[c] && !ss[c]));
      raw[c]    = active[c] && cnt[c] < wid_a[c];
    end
  end

  assign pwm_out = {raw[3], raw[2], raw[1], burst ? (raw[0] & raw[1]) : raw[0]};
  assign irq     = |(flag & ien);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0: rd_data = {4'b0, flag, 4'b0, run};
      4'd1: rd_data = ctrlb;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == 4'(8 + 2*c)) rd_data = 16'(per_h[c]);
      if (rd_addr == 4'(9 + 2*c)) rd_data = 16'(wid_h[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      flag   <= '0;
      ctrlb  <= '0;
      active <= '0;
      for (int c = 0; c < NCH; c++) begin
        per_h[c] <= '0;
        wid_h[c] <= '0;
        per_a[c] <= '0;
        wid_a[c] <= '0;
        cnt[c]   <= '0;
      end
    end else begin
      if (wr_en && wr_addr == 4'd0) begin
        run  <= wr_data[3:0] & ~fin;
        flag <= (flag & wr_data[11:8]) | reload;
      end else begin
        run  <= run & ~fin;
        flag <= flag | reload;
      end
      if (wr_en) begin
        case (wr_addr)
          4'd1: ctrlb <= wmask;
          4'd2: ctrlb <= ctrlb | wmask;
          4'd3: ctrlb <= ctrlb & ~wmask;
          default: ;
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && wr_addr == 4'(8 + 2*c)) per_h[c] <= wr_data[CW-1:0];
        if (wr_en && wr_addr == 4'(9 + 2*c)) wid_h[c] <= wr_data[CW-1:0];
        if (reload[c]) begin
          per_a[c]  <= per_h[c];
          wid_a[c]  <= wid_h[c];
          cnt[c]    <= '0;
          active[c] <= 1'b1;
        end else if (active[c] && (!run[c] || fin[c])) begin
          active[c] <= 1'b0;
          cnt[c]    <= '0;
        end else if (active[c]) begin
          cnt[c] <= cnt[c] + 1'b1;
        end
      end
    end
  end

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlb & ~B_MASK) == 16'h0);

  assert_burst_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && pwm_out[0]) |-> pwm_out[1]);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active[g] |-> cnt[g] <= per_a[g]);
    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active[g] && run[g] && !ss[g] && cnt[g] == per_a[g]) |=> (cnt[g] == '0 && flag[g] && active[g]));
    assert_single_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active[g] && ss[g] && cnt[g] == per_a[g]) |=> (!active[g] && !run[g]));
    assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[g] |-> active[g]);
  end
endmodule

// File: tb/pwm4_irq_test.sv
`timescale 1ns/1ps
module pwm4_irq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  pwm_out;
  logic        irq;
  int checks = 0, errors = 0;

  pwm4_irq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .irq(irq));

  always #5 clk = ~clk;

  // {addr, data, expected control B}
  localparam logic [35:0] VEC [10] = '{
    {4'd1, 16'hFFFF, 16'hD0FF},
    {4'd3, 16'h00F0, 16'hD00F},
    {4'd3, 16'h0000, 16'hD00F},
    {4'd2, 16'h0000, 16'hD00F},
    {4'd2, 16'h2F00, 16'hD00F},
    {4'd3, 16'h1001, 16'hC00E},
    {4'd2, 16'h0030, 16'hC03E},
    {4'd1, 16'h0000, 16'h0000},
    {4'd2, 16'h1000, 16'h1000},
    {4'd3, 16'h1000, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, v); chk(v == 0, "R1 ctrlA", v, 0);
    rd(4'd1, v); chk(v == 0, "R1 ctrlB", v, 0);
    rd(4'd9, v); chk(v == 0, "R1 width0", v, 0);
    chk(pwm_out == 0 && irq == 0, "R1 outputs", {pwm_out, irq}, 0);

    // R7 R8 R9 alias walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(4'd1, v);
      chk(v == VEC[i][15:0], "R7/R8/R9 ctrlB", v, VEC[i][15:0]);
    end
    rd(4'd2, v); chk(v == 0, "R9 alias reads 0", v, 0);

    // R2 R4 channel 0: period 3, width 2 -> 1100
    wr(4'd8, 16'd3); wr(4'd9, 16'd2);
    wr(4'd0, 16'h0001);
    chk(pwm_out[0] == 0, "R4 not yet started", pwm_out[0], 0);
    for (int k = 0; k < 8; k++) begin
      step();
      chk(pwm_out[0] == ((k % 4) < 2), "R2 waveform", pwm_out[0], (k % 4) < 2);
    end
    rd(4'd0, v); chk(v == 16'h0101, "R4 flag set", v, 16'h0101);
    // R6 clear captured on wrap edge: hardware wins
    wr(4'd0, 16'h0001);
    rd(4'd0, v); chk(v == 16'h0101, "R6 set wins", v, 16'h0101);
    step();
    wr(4'd0, 16'h0001);
    rd(4'd0, v); chk(v == 16'h0001, "R6 flag cleared", v, 16'h0001);
    // R5 interrupt gating
    wr(4'd1, 16'h0001);
    chk(irq == 0, "R5 no flag", irq, 0);
    step();
    chk(irq == 1, "R5 enabled flag", irq, 1);
    wr(4'd3, 16'h0001);
    chk(irq == 0, "R5 disabled", irq, 0);
    // R2 shadow: width 4 written at count 1 applies next cycle
    wr(4'd9, 16'd4);
    chk(pwm_out[0] == 0, "R2 old width held", pwm_out[0], 0);
    step(); step();
    for (int k = 0; k < 4; k++) begin
      chk(pwm_out[0] == 1, "R3 width above period", pwm_out[0], 1);
      if (k < 3) step();
    end
    // width 0 written on the reload edge: old value loads first
    wr(4'd9, 16'd0);
    for (int k = 0; k < 4; k++) begin
      chk(pwm_out[0] == 1, "R2 same-edge write", pwm_out[0], 1);
      step();
    end
    for (int k = 0; k < 4; k++) begin
      chk(pwm_out[0] == 0, "R3 width zero", pwm_out[0], 0);
      step();
    end
    wr(4'd0, 16'h0000);
    step(); step();

    // R12 stop on channel 2
    wr(4'd12, 16'd3); wr(4'd13, 16'd4);
    wr(4'd0, 16'h0004);
    step();
    chk(pwm_out[2] == 1, "R12 running", pwm_out[2], 1);
    wr(4'd0, 16'h0000);
    step();
    chk(pwm_out[2] == 0, "R12 stopped", pwm_out[2], 0);
    step(); step();
    chk(pwm_out[2] == 0, "R12 stays low", pwm_out[2], 0);

    // R11 single shot on channel 3: period 2, width 1
    wr(4'd2, 16'h0080);
    wr(4'd14, 16'd2); wr(4'd15, 16'd1);
    wr(4'd0, 16'h0008);
    step();
    chk(pwm_out[3] == 1, "R11 first count", pwm_out[3], 1);
    step(); step(); step();
    chk(pwm_out[3] == 0, "R11 stopped", pwm_out[3], 0);
    rd(4'd0, v); chk(v == 16'h0800, "R11 run cleared", v, 16'h0800);
    step(); step();
    chk(pwm_out[3] == 0, "R11 no restart", pwm_out[3], 0);

    // R10 burst: ch0 1100, ch1 1000
    wr(4'd3, 16'h0080);
    wr(4'd9, 16'd2); wr(4'd10, 16'd3); wr(4'd11, 16'd1);
    wr(4'd2, 16'h1000);
    wr(4'd0, 16'h0003);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(pwm_out[0] == (k == 0), "R10 burst AND", pwm_out[0], k == 0);
      chk(pwm_out[1] == (k == 0), "R10 ch1 alone", pwm_out[1], k == 0);
    end
    wr(4'd3, 16'h1000);
    step();
    chk(pwm_out[0] == 1, "R10 burst off", pwm_out[0], 1);
    wr(4'd0, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule